// File: doc/BRIEF.md
# Byte-Select Writer for a Multiplexed 16-Bit External Bus

This block lets an 8-bit core store single bytes into a word-wide external memory that shares one 16-bit line set between address and data. A request carries one data byte and a 21-bit byte pointer. The block then runs a fixed write cycle. In the first clock it puts the word address on the shared lines and raises the latch enable. After that it drives the data, pulses the write strobe and holds the data for one more clock.

The upper strobe is the only write strobe the block uses. The lower strobe is never pulsed. The byte goes out on both halves of the data bus. The target half is named by bit 0 of the pointer, which the block presents in two forms. The first is a plain byte-address line, which suits word/byte-configurable Flash. The second is a pair of active-low upper/lower enables, which suits static RAM.

A configuration input chooses 16-bit or 20-bit word addressing. In 20-bit mode, four extra upper address lines carry the top of the word address.

Top module: `mux_bytewr`

## Requirements
- R1: While reset (synchronous, active high) is applied and in the cycle after it is released, the block is idle: `req_ready`=1, `ale`=0, `ad_oe`=0, `ad_out`=0, `a_hi`=0, `ba0`=0, and `wrh_n`, `wrl_n`, `oe_n`, `ub_n`, `lb_n` are all 1.
- R2: In the clock after a request is accepted (`req_valid` and `req_ready` high at a rising edge), `ale`=1 for exactly one clock. During that clock `ad_oe`=1 and `ad_out` equals pointer bits [16:1]. Pointer bit 0 never appears in the address.
- R3: In every clock of the cycle after the address clock, `ad_oe`=1 and `ad_out` is the request byte on both halves, i.e. {byte, byte}.
- R4: The data-driven clocks run in this order: one setup clock with `wrh_n`=1, then `WR_CYC` clocks with `wrh_n`=0, then one hold clock with `wrh_n`=1. `wrh_n` goes low for exactly one run per write, whatever byte is addressed.
- R5: `wrl_n` and `oe_n` stay 1 at all times.
- R6: From the address clock through the hold clock, `ba0` equals pointer bit 0, `ub_n` = NOT bit 0 and `lb_n` = bit 0. At all other times `ba0`=0 and `ub_n`=`lb_n`=1.
- R7: `a_hi` carries pointer bits [20:17] for the whole cycle when `wide_en` was 1 at acceptance. It is 0 when `wide_en` was 0 and whenever the block is idle. A change of `wide_en` during a cycle has no effect on that cycle.
- R8: `req_ready` is 0 from the clock after acceptance through the hold clock and 1 in the clock after hold, so a new request can be taken at the end of that clock. A request held while busy is ignored, and inputs change nothing once they have been taken.
- R9: `ad_oe` is 0 whenever the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Write request present |
| req_ready | output | 1 | Block can accept a request |
| req_byte | input | 8 | Byte to store |
| req_ptr | input | 21 | Byte pointer; bit 0 selects the half, [20:1] is the word address |
| wide_en | input | 1 | 1 = 20-bit word address, 0 = 16-bit |
| ad_out | output | 16 | Shared address/data lines, output value |
| ad_oe | output | 1 | Output enable for the shared lines |
| a_hi | output | 4 | Upper word address lines [19:16] |
| ale | output | 1 | Address latch enable, active high |
| oe_n | output | 1 | Memory read enable, active low |
| wrh_n | output | 1 | Write strobe, active low |
| wrl_n | output | 1 | Lower write strobe, active low, never used |
| ba0 | output | 1 | Byte address line |
| ub_n | output | 1 | Upper byte enable, active low |
| lb_n | output | 1 | Lower byte enable, active low |

## Verification
Each result has a due cycle. Counting from the rising edge that accepts a request:
- the address clock is due one clock later;
- setup follows at two;
- the strobe occupies clocks three through 2+`WR_CYC`;
- hold falls at 3+`WR_CYC`;
- `req_ready` returns one clock after hold.

The bench predicts this schedule independently. At each accepted request it pushes one expected output set per future clock into a queue. At every falling edge it pops one entry, or an idle set when the queue is empty, and compares all outputs. Acceptance is predicted only when the expected set for the current clock shows the block ready. This keeps the busy-time requests and the mid-cycle `wide_en` changes that must be ignored aligned to the right clock.

// File: rtl/mux_bytewr.sv
module mux_bytewr #(
  parameter int WR_CYC = 1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [7:0]  req_byte,
  input  logic [20:0] req_ptr,
  input  logic        wide_en,
  output logic [15:0] ad_out,
  output logic        ad_oe,
  output logic [3:0]  a_hi,
  output logic        ale,
  output logic        oe_n,
  output logic        wrh_n,
  output logic        wrl_n,
  output logic        ba0,
  output logic        ub_n,
  output logic        lb_n
);
  localparam int CW = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;

  typedef enum logic [2:0] {S_IDLE, S_ADDR, S_SETUP, S_STRB, S_HOLD} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [7:0]   dat;
  logic [20:0]  ptr;
  logic         wide;
  logic         busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= S_IDLE;
      cnt  <= '0;
      dat  <= '0;
      ptr  <= '0;
      wide <= 1'b0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          dat  <= req_byte;
          ptr  <= req_ptr;
          wide <= wide_en;
          st   <= S_ADDR;
        end
        S_ADDR:  st <= S_SETUP;
        S_SETUP: begin
          cnt <= CW'(WR_CYC - 1);
          st  <= S_STRB;
        end
        S_STRB: begin
          if (cnt == '0) st <= S_HOLD;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign busy      = (st != S_IDLE);
  assign req_ready = !busy;
  assign ale       = (st == S_ADDR);
  assign ad_oe     = busy;
  assign ad_out    = ale ? ptr[16:1] : (busy ? {dat, dat} : 16'h0000);
  assign a_hi      = (busy && wide) ? ptr[20:17] : 4'h0;
  assign oe_n      = 1'b1;
  assign wrl_n     = 1'b1;
  assign wrh_n     = (st != S_STRB);
  assign ba0       = busy && ptr[0];
  assign ub_n      = !(busy && ptr[0]);
  assign lb_n      = !(busy && !ptr[0]);
endmodule

// File: rtl/mux_bytewr_chk.sv
module mux_bytewr_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_valid,
  input logic        req_ready,
  input logic [15:0] ad_out,
  input logic        ad_oe,
  input logic        ale,
  input logic        oe_n,
  input logic        wrh_n,
  input logic        wrl_n,
  input logic        ba0,
  input logic        ub_n,
  input logic        lb_n
);
  // R5
  unused_strobes_chk: assert property (@(posedge clk) disable iff (rst) wrl_n && oe_n);

  // R3
  lanes_match_chk: assert property (@(posedge clk) disable iff (rst)
    !wrh_n |-> (ad_oe && ad_out[15:8] == ad_out[7:0]));

  // R6
  lane_select_chk: assert property (@(posedge clk) disable iff (rst)
    ad_oe |-> ((ub_n != lb_n) && (ba0 == lb_n)));

  // R2
  ale_single_chk: assert property (@(posedge clk) disable iff (rst)
    ale |=> (!ale && ad_oe));

  // R8
  accept_start_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (ale && !req_ready));

  // R4
  strobe_after_addr_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(wrh_n) |-> (!ale && ad_oe && !req_ready));

  // R9
  idle_bus_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (!ad_oe && wrh_n && ub_n && lb_n));
endmodule

bind mux_bytewr mux_bytewr_chk u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .ad_out(ad_out), .ad_oe(ad_oe), .ale(ale), .oe_n(oe_n), .wrh_n(wrh_n),
  .wrl_n(wrl_n), .ba0(ba0), .ub_n(ub_n), .lb_n(lb_n)
);

// File: tb/mux_bytewr_tb.sv
`timescale 1ns/1ps
module mux_bytewr_tb;
  localparam int WR = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic [7:0]  req_byte = '0;
  logic [20:0] req_ptr = '0;
  logic        wide_en = 1'b0;
  logic        req_ready, ad_oe, ale, oe_n, wrh_n, wrl_n, ba0, ub_n, lb_n;
  logic [15:0] ad_out;
  logic [3:0]  a_hi;

  always #2.5 clk = ~clk;

  mux_bytewr #(.WR_CYC(WR)) u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_byte(req_byte), .req_ptr(req_ptr), .wide_en(wide_en),
    .ad_out(ad_out), .ad_oe(ad_oe), .a_hi(a_hi), .ale(ale), .oe_n(oe_n),
    .wrh_n(wrh_n), .wrl_n(wrl_n), .ba0(ba0), .ub_n(ub_n), .lb_n(lb_n)
  );

  typedef struct packed {
    logic        rdy;
    logic        ale;
    logic        oe;
    logic [15:0] ad;
    logic [3:0]  hi;
    logic        wrh_n;
    logic        ba0;
    logic        ub_n;
    logic        lb_n;
  } exp_t;

  exp_t q[$];
  int   n_cmp = 0;
  int   n_bad = 0;

  function automatic exp_t idle_v();
    exp_t e;
    e.rdy = 1'b1; e.ale = 1'b0; e.oe = 1'b0; e.ad = '0; e.hi = '0;
    e.wrh_n = 1'b1; e.ba0 = 1'b0; e.ub_n = 1'b1; e.lb_n = 1'b1;
    return e;
  endfunction

  task automatic cmp(input string req, input string nm, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, nm, act, exp, $time);
    end
  endtask

  task automatic check_all(input exp_t e);
    cmp("R8", "req_ready", int'(req_ready), int'(e.rdy));
    cmp("R2", "ale", int'(ale), int'(e.ale));
    cmp("R9", "ad_oe", int'(ad_oe), int'(e.oe));
    cmp("R2 R3", "ad_out", int'(ad_out), int'(e.ad));
    cmp("R7", "a_hi", int'(a_hi), int'(e.hi));
    cmp("R4", "wrh_n", int'(wrh_n), int'(e.wrh_n));
    cmp("R5", "wrl_n", int'(wrl_n), 1);
    cmp("R5", "oe_n", int'(oe_n), 1);
    cmp("R6", "ba0", int'(ba0), int'(e.ba0));
    cmp("R6", "ub_n", int'(ub_n), int'(e.ub_n));
    cmp("R6", "lb_n", int'(lb_n), int'(e.lb_n));
  endtask

  task automatic push_write(input logic [7:0] d, input logic [20:0] p, input logic w);
    exp_t e;
    e.rdy = 1'b0; e.oe = 1'b1; e.hi = w ? p[20:17] : 4'h0;
    e.ba0 = p[0]; e.ub_n = !p[0]; e.lb_n = p[0];
    e.ale = 1'b1; e.ad = p[16:1]; e.wrh_n = 1'b1;
    q.push_back(e);
    e.ale = 1'b0; e.ad = {d, d};
    q.push_back(e);
    e.wrh_n = 1'b0;
    for (int k = 0; k < WR; k++) q.push_back(e);
    e.wrh_n = 1'b1;
    q.push_back(e);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    exp_t e;
    repeat (3) @(negedge clk);
    // R1: idle during reset
    check_all(idle_v());
    rst = 1'b0;
    @(negedge clk);
    // R1: idle after release
    check_all(idle_v());
    for (int i = 0; i < 600; i++) begin
      @(negedge clk);
      e = (q.size() != 0) ? q.pop_front() : idle_v();
      check_all(e);
      req_byte = 8'($urandom);
      wide_en  = 1'($urandom);
      case (i % 8)
        0: req_ptr = 21'h000000;
        1: req_ptr = 21'h1FFFFF;
        2: req_ptr = 21'h155555;
        3: req_ptr = 21'h0AAAAA;
        default: req_ptr = 21'($urandom);
      endcase
      if (i < 100)      req_valid = 1'b1;
      else if (i < 300) req_valid = ($urandom % 3) != 0;
      else              req_valid = ($urandom % 4) == 0;
      if (req_valid && e.rdy) push_write(req_byte, req_ptr, wide_en);
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule